// File: doc/BRIEF.md
# 8b/10b Line Encoder with Running Disparity

This block turns one byte per clock into a 10-bit DC-balanced line symbol. The five low bits of the byte go through a 5-to-6 bit sub-coder. The three high bits go through a 3-to-4 bit sub-coder. A control flag asks for a special (non-data) character in place of the data byte. The two code groups are joined into a single symbol, with the 6-bit group first on the line. The result is registered together with the disparity it leaves behind, so a serializer can shift the symbol out with bit 9 first.

Balance comes from a two-state disparity machine. Its states are `RD_NEG` (more zeros sent so far; the reset state) and `RD_POS` (more ones sent so far). It has two transitions. FLIP moves to the other state when an accepted symbol carries unequal numbers of ones and zeros. HOLD keeps the state when the symbol is balanced, or when no byte is presented. Each sub-block has two forms, one the inverse of the other, and the choice between them is made per sub-block. The 6-bit group is chosen from the disparity at the start of the symbol. The 4-bit group is chosen from the disparity left after the 6-bit group. Control requests outside the permitted set raise an error flag and are coded as plain data.

Top module: `lc_enc8b10b`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid`=0, `out_kerr`=0, `out_sym`=0 and `out_rd`=0 (0 means negative disparity, 1 means positive).
- R2: A byte presented with `in_valid`=1 at a rising edge appears on `out_sym` with `out_valid`=1 right after that edge. A cycle without `in_valid` gives `out_valid`=0 and leaves `out_rd` unchanged.
- R3: `out_sym[9:4]` is the 6-bit code of `in_byte[4:0]` and `out_sym[3:0]` is the 4-bit code of `in_byte[7:5]`. The 6-bit group holds 2 to 4 ones and the 4-bit group holds 1 to 3 ones.
- R4: An unbalanced sub-block code is sent in the form that moves disparity back across zero. The 6-bit form is chosen by the disparity at symbol start, and the 4-bit form by the disparity after the 6-bit group. Every unbalanced symbol flips `out_rd`.
- R5: 5-bit value 7 is sent as 111000 from negative disparity and 000111 from positive disparity. 3-bit value 3 is sent as 1100 after a negative 6-bit group and 0011 after a positive one. Both leave disparity unchanged.
- R6: Every symbol holds 4, 5 or 6 ones. The ones-minus-zeros sum over the whole stream, starting at -1, ends every symbol at -1 or +1, matching `out_rd`.
- R7: The serial stream never holds more than five equal consecutive bits. For 3-bit value 7, the alternate form 0111 is used after a negative 6-bit group for 5-bit values 17, 18 and 20. The alternate form 1000 is used after a positive 6-bit group for 11, 13 and 14.
- R8: With `in_ctrl`=1, exactly twelve bytes are accepted: 5-bit value 28 with any 3-bit value, and 5-bit values 23, 27, 29, 30 with 3-bit value 7. Value 28 codes as 001111 or 110000 in the 6-bit group. Control characters with 3-bit value 7 always use the alternate 4-bit form.
- R9: The comma character (`in_ctrl`=1, byte 0xBC) codes as 0011111010 from negative disparity and 1100000101 from positive disparity.
- R10: A control request outside the permitted set gives `out_kerr`=1 for that symbol. The symbol and disparity are then those of the same byte sent as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A byte is presented this cycle |
| in_ctrl | input | 1 | Byte requests a control character |
| in_byte | input | 8 | Data byte or control code |
| out_valid | output | 1 | `out_sym` holds a new symbol |
| out_sym | output | 10 | Encoded symbol, bit 9 sent first |
| out_rd | output | 1 | Disparity after the last symbol (1 = positive) |
| out_kerr | output | 1 | Control request was outside the permitted set |

## Verification
The hardest condition to reach is a chosen byte arriving at a chosen starting disparity, because disparity is hidden state that only the history of the stream sets. The bench keeps its own disparity model. Before each byte, it inserts a single unbalanced data symbol (byte 0x60) whenever the model disagrees with the wanted start. That lets every data byte and every control character be swept from both disparities. A long pseudo-random mix then checks run length and the stream sum across symbol boundaries.

// File: rtl/lc8b10b_pkg.sv
package lc8b10b_pkg;

    localparam int BYTE_W    = 8;
    localparam int LO_W      = 5;
    localparam int HI_W      = BYTE_W - LO_W;
    localparam int LO_CODE_W = LO_W + 1;
    localparam int HI_CODE_W = HI_W + 1;
    localparam int SYM_W     = LO_CODE_W + HI_CODE_W;

    localparam logic [LO_W-1:0] K_MAIN = 5'd28;

    typedef enum logic {
        RD_NEG = 1'b0,
        RD_POS = 1'b1
    } rd_state_t;

    function automatic rd_state_t rd_other(input rd_state_t r);
        return (r == RD_POS) ? RD_NEG : RD_POS;
    endfunction

endpackage

// File: rtl/lc_kcheck.sv
module lc_kcheck
    import lc8b10b_pkg::*;
(
    input  logic [LO_W-1:0] lo,
    input  logic [HI_W-1:0] hi,
    input  logic            ctrl,
    output logic            k_ok,
    output logic            k_err
);
    logic allowed;

    always_comb begin
        allowed = (lo == K_MAIN) ||
                  ((hi == 3'd7) && ((lo == 5'd23) || (lo == 5'd27) ||
                                    (lo == 5'd29) || (lo == 5'd30)));
        k_ok  = ctrl && allowed;
        k_err = ctrl && !allowed;
    end
endmodule

// File: rtl/lc_enc6.sv
module lc_enc6
    import lc8b10b_pkg::*;
(
    input  logic [LO_W-1:0]      lo,
    input  logic                 k28,
    input  rd_state_t            rd_in,
    output logic [LO_CODE_W-1:0] code,
    output rd_state_t            rd_mid
);
    logic [LO_CODE_W-1:0] neg_form;
    logic                 invert;

    always_comb begin
        neg_form = '0;
        unique case (lo)
            5'd0:  neg_form = 6'b100111;
            5'd1:  neg_form = 6'b011101;
            5'd2:  neg_form = 6'b101101;
            5'd3:  neg_form = 6'b110001;
            5'd4:  neg_form = 6'b110101;
            5'd5:  neg_form = 6'b101001;
            5'd6:  neg_form = 6'b011001;
            5'd7:  neg_form = 6'b111000;
            5'd8:  neg_form = 6'b111001;
            5'd9:  neg_form = 6'b100101;
            5'd10: neg_form = 6'b010101;
            5'd11: neg_form = 6'b110100;
            5'd12: neg_form = 6'b001101;
            5'd13: neg_form = 6'b101100;
            5'd14: neg_form = 6'b011100;
            5'd15: neg_form = 6'b010111;
            5'd16: neg_form = 6'b011011;
            5'd17: neg_form = 6'b100011;
            5'd18: neg_form = 6'b010011;
            5'd19: neg_form = 6'b110010;
            5'd20: neg_form = 6'b001011;
            5'd21: neg_form = 6'b101010;
            5'd22: neg_form = 6'b011010;
            5'd23: neg_form = 6'b111010;
            5'd24: neg_form = 6'b110011;
            5'd25: neg_form = 6'b100110;
            5'd26: neg_form = 6'b010110;
            5'd27: neg_form = 6'b110110;
            5'd28: neg_form = 6'b001110;
            5'd29: neg_form = 6'b101110;
            5'd30: neg_form = 6'b011110;
            5'd31: neg_form = 6'b101011;
        endcase
        if (k28) neg_form = 6'b001111;

        invert = (rd_in == RD_POS) &&
                 (($countones(neg_form) != 3) || (!k28 && lo == 5'd7));
        code   = invert ? ~neg_form : neg_form;
        rd_mid = ($countones(code) != 3) ? rd_other(rd_in) : rd_in;
    end
endmodule

// File: rtl/lc_enc4.sv
module lc_enc4
    import lc8b10b_pkg::*;
(
    input  logic [HI_W-1:0]      hi,
    input  logic [LO_W-1:0]      lo,
    input  logic                 k_any,
    input  logic                 k28,
    input  rd_state_t            rd_mid,
    output logic [HI_CODE_W-1:0] code,
    output rd_state_t            rd_end
);
    logic [HI_CODE_W-1:0] neg_form;
    logic                 use_alt;
    logic                 invert;

    always_comb begin
        neg_form = '0;
        unique case (hi)
            3'd0: neg_form = 4'b1011;
            3'd1: neg_form = k28 ? 4'b0110 : 4'b1001;
            3'd2: neg_form = k28 ? 4'b1010 : 4'b0101;
            3'd3: neg_form = 4'b1100;
            3'd4: neg_form = 4'b1101;
            3'd5: neg_form = k28 ? 4'b0101 : 4'b1010;
            3'd6: neg_form = k28 ? 4'b1001 : 4'b0110;
            3'd7: neg_form = 4'b1110;
        endcase

        use_alt = (hi == 3'd7) &&
                  (k_any ||
                   ((rd_mid == RD_NEG) && (lo == 5'd17 || lo == 5'd18 || lo == 5'd20)) ||
                   ((rd_mid == RD_POS) && (lo == 5'd11 || lo == 5'd13 || lo == 5'd14)));
        if (use_alt) neg_form = 4'b0111;

        invert = (rd_mid == RD_POS) &&
                 (($countones(neg_form) != 2) || (hi == 3'd3) || k28);
        code   = invert ? ~neg_form : neg_form;
        rd_end = ($countones(code) != 2) ? rd_other(rd_mid) : rd_mid;
    end
endmodule

// File: rtl/lc_enc8b10b.sv
module lc_enc8b10b
    import lc8b10b_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_ctrl,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_valid,
    output logic [SYM_W-1:0]  out_sym,
    output logic              out_rd,
    output logic              out_kerr
);
    rd_state_t            rd_q, rd_d, rd_mid, rd_end;
    logic [LO_W-1:0]      lo;
    logic [HI_W-1:0]      hi;
    logic                 k_ok, k_err, k28;
    logic [LO_CODE_W-1:0] c6;
    logic [HI_CODE_W-1:0] c4;

    assign lo  = in_byte[LO_W-1:0];
    assign hi  = in_byte[BYTE_W-1:LO_W];
    assign k28 = k_ok && (lo == K_MAIN);

    lc_kcheck u_kcheck (
        .lo    (lo),
        .hi    (hi),
        .ctrl  (in_ctrl),
        .k_ok  (k_ok),
        .k_err (k_err)
    );

    lc_enc6 u_enc6 (
        .lo     (lo),
        .k28    (k28),
        .rd_in  (rd_q),
        .code   (c6),
        .rd_mid (rd_mid)
    );

    lc_enc4 u_enc4 (
        .hi     (hi),
        .lo     (lo),
        .k_any  (k_ok),
        .k28    (k28),
        .rd_mid (rd_mid),
        .code   (c4),
        .rd_end (rd_end)
    );

    // next state: FLIP on an unbalanced symbol, HOLD otherwise
    always_comb begin
        rd_d = rd_q;
        unique case (rd_q)
            RD_NEG: if (in_valid && rd_end == RD_POS) rd_d = RD_POS;
            RD_POS: if (in_valid && rd_end == RD_NEG) rd_d = RD_NEG;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= RD_NEG;
        else        rd_q <= rd_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_kerr  <= 1'b0;
            out_sym   <= '0;
        end else begin
            out_valid <= in_valid;
            out_kerr  <= in_valid && k_err;
            if (in_valid) out_sym <= {c6, c4};
        end
    end

    assign out_rd = (rd_q == RD_POS);
endmodule

// File: rtl/lc_enc8b10b_chk.sv
module lc_enc8b10b_chk
    import lc8b10b_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic [SYM_W-1:0] out_sym,
    input logic             out_rd,
    input logic             out_kerr
);
    function automatic logic run_ok(input logic [SYM_W-1:0] s);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i + 5 < SYM_W; i++) begin
            if (s[i +: 6] == 6'b000000 || s[i +: 6] == 6'b111111) ok = 1'b0;
        end
        return ok;
    endfunction

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_rd && !out_valid && !out_kerr)); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_rd)); // R2
    AST_SUB_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_sym[9:4]) inside {2, 3, 4} &&
                       $countones(out_sym[3:0]) inside {1, 2, 3})); // R3
    AST_UNBAL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $countones(out_sym) != 5) |-> (out_rd != $past(out_rd))); // R4
    AST_SYM_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_sym) inside {4, 5, 6})); // R6
    AST_HEAVY_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $countones(out_sym) == 6) |-> out_rd); // R6
    AST_BAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $countones(out_sym) == 5) |-> $stable(out_rd)); // R6
    AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> run_ok(out_sym)); // R7
    AST_KERR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_kerr |-> out_valid); // R10
endmodule

bind lc_enc8b10b lc_enc8b10b_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_sym   (out_sym),
    .out_rd    (out_rd),
    .out_kerr  (out_kerr)
);

// File: tb/lc_enc8b10b_bench.sv
module lc_enc8b10b_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_ctrl;
    logic [7:0] in_byte;
    logic       out_valid, out_rd, out_kerr;
    logic [9:0] out_sym;

    int   n_run = 0, n_fail = 0;
    logic model_rd = 1'b0;
    int   run_len = 0;
    logic last_bit = 1'b0;
    int   rsum = -1;
    bit   done = 0;

    always #2 clk = ~clk;

    lc_enc8b10b u_lc_enc8b10b (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
        .in_byte(in_byte), .out_valid(out_valid), .out_sym(out_sym),
        .out_rd(out_rd), .out_kerr(out_kerr)
    );

    function automatic logic [5:0] tb_six(input logic [4:0] x);
        case (x)
            0: return 6'b100111;  1: return 6'b011101;  2: return 6'b101101;
            3: return 6'b110001;  4: return 6'b110101;  5: return 6'b101001;
            6: return 6'b011001;  7: return 6'b111000;  8: return 6'b111001;
            9: return 6'b100101; 10: return 6'b010101; 11: return 6'b110100;
           12: return 6'b001101; 13: return 6'b101100; 14: return 6'b011100;
           15: return 6'b010111; 16: return 6'b011011; 17: return 6'b100011;
           18: return 6'b010011; 19: return 6'b110010; 20: return 6'b001011;
           21: return 6'b101010; 22: return 6'b011010; 23: return 6'b111010;
           24: return 6'b110011; 25: return 6'b100110; 26: return 6'b010110;
           27: return 6'b110110; 28: return 6'b001110; 29: return 6'b101110;
           30: return 6'b011110; default: return 6'b101011;
        endcase
    endfunction

    function automatic logic [3:0] tb_four(input logic [2:0] y);
        case (y)
            0: return 4'b1011; 1: return 4'b1001; 2: return 4'b0101; 3: return 4'b1100;
            4: return 4'b1101; 5: return 4'b1010; 6: return 4'b0110; default: return 4'b1110;
        endcase
    endfunction

    function automatic logic [7:0] kcode(input int i);
        case (i)
            8:  return {3'd7, 5'd23};
            9:  return {3'd7, 5'd27};
            10: return {3'd7, 5'd29};
            11: return {3'd7, 5'd30};
            default: return {i[2:0], 5'd28};
        endcase
    endfunction

    task automatic model(input logic [7:0] b, input logic k, input logic rd,
                         output logic [9:0] sym, output logic rdo, output logic kerr);
        logic [4:0] x;
        logic [2:0] y;
        logic kv, rdm;
        logic [5:0] six;
        logic [3:0] four;
        x = b[4:0];
        y = b[7:5];
        kv = k && (x == 28 || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30)));
        kerr = k && !kv;
        if (kv && x == 28)  six = rd ? 6'b110000 : 6'b001111;
        else if (x == 7)    six = rd ? 6'b000111 : 6'b111000;
        else begin
            six = tb_six(x);
            if (rd && $countones(six) == 4) six = ~six;
        end
        rdm = rd ^ ($countones(six) != 3);
        if (y == 7 && (kv || (!rdm && six[1:0] == 2'b11) || (rdm && six[1:0] == 2'b00)))
            four = rdm ? 4'b1000 : 4'b0111;
        else if (kv && x == 28 && (y == 1 || y == 2 || y == 5 || y == 6))
            four = rdm ? tb_four(y) : ~tb_four(y);
        else if (y == 3)
            four = rdm ? 4'b0011 : 4'b1100;
        else begin
            four = tb_four(y);
            if (rdm && $countones(four) == 3) four = ~four;
        end
        sym = {six, four};
        rdo = rdm ^ ($countones(four) != 2);
    endtask

    task automatic check(input bit ok, input string tag, input string what);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s", tag, what);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic k, input string tag);
        logic [9:0] es;
        logic er, ek;
        int worst;
        @(negedge clk);
        in_valid = 1'b1; in_byte = b; in_ctrl = k;
        @(posedge clk); #1;
        model(b, k, model_rd, es, er, ek);
        check(out_valid && out_sym == es && out_rd == er && out_kerr == ek, tag,
              $sformatf("byte %h k %0d rd0 %0d: got v%0d sym %b rd %0d kerr %0d, expected v1 sym %b rd %0d kerr %0d",
                        b, k, model_rd, out_valid, out_sym, out_rd, out_kerr, es, er, ek));
        model_rd = er;
        worst = 0;
        for (int i = 9; i >= 0; i--) begin
            if (out_sym[i] == last_bit) run_len++; else run_len = 1;
            last_bit = out_sym[i];
            if (run_len > worst) worst = run_len;
        end
        rsum += 2 * $countones(out_sym) - 10;
        check(worst <= 5, "R7", $sformatf("run length %0d, expected <= 5", worst));
        check(rsum == (out_rd ? 1 : -1), "R6",
              $sformatf("stream sum %0d, expected %0d", rsum, out_rd ? 1 : -1));
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    task automatic start_at(input logic rd);
        if (model_rd != rd) send(8'h60, 1'b0, "R4");
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic hold_rd;
        logic [15:0] lfsr;
        rst_n = 1'b0; in_valid = 1'b0; in_ctrl = 1'b0; in_byte = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        check(!out_valid && !out_kerr && !out_rd && out_sym == 10'd0, "R1",
              $sformatf("in reset v%0d kerr%0d rd%0d sym %b, expected all 0",
                        out_valid, out_kerr, out_rd, out_sym));
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(!out_valid && !out_kerr && !out_rd, "R1",
              $sformatf("after reset v%0d kerr%0d rd%0d, expected 0", out_valid, out_kerr, out_rd));

        // every data byte from both disparities (R3, R4, R5, R7)
        for (int r = 0; r < 2; r++)
            for (int b = 0; b < 256; b++) begin
                start_at(r[0]);
                send(b[7:0], 1'b0, "R3");
            end

        // sub-block special cases from named disparities
        start_at(1'b0); send(8'h07, 1'b0, "R5");
        check(out_sym[9:4] == 6'b111000, "R5", $sformatf("D7 from neg got %b expected 111000", out_sym[9:4]));
        start_at(1'b1); send(8'h07, 1'b0, "R5");
        check(out_sym[9:4] == 6'b000111, "R5", $sformatf("D7 from pos got %b expected 000111", out_sym[9:4]));
        start_at(1'b0); send(8'hF1, 1'b0, "R7");
        check(out_sym[3:0] == 4'b0111, "R7", $sformatf("D17.7 neg got %b expected 0111", out_sym[3:0]));
        start_at(1'b1); send(8'hEB, 1'b0, "R7");
        check(out_sym[3:0] == 4'b1000, "R7", $sformatf("D11.7 pos got %b expected 1000", out_sym[3:0]));

        // all permitted control characters from both disparities
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < 12; i++) begin
                start_at(r[0]);
                send(kcode(i), 1'b1, "R8");
            end

        // comma literal
        start_at(1'b0); send(8'hBC, 1'b1, "R9");
        check(out_sym == 10'b0011111010, "R9", $sformatf("comma neg got %b expected 0011111010", out_sym));
        start_at(1'b1); send(8'hBC, 1'b1, "R9");
        check(out_sym == 10'b1100000101, "R9", $sformatf("comma pos got %b expected 1100000101", out_sym));

        // rejected control requests
        for (int r = 0; r < 2; r++) begin
            start_at(r[0]); send(8'hE0, 1'b1, "R10");
            start_at(r[0]); send(8'h77, 1'b1, "R10");
            start_at(r[0]); send(8'h15, 1'b1, "R10");
        end

        // idle cycles hold disparity
        for (int r = 0; r < 2; r++) begin
            start_at(r[0]);
            hold_rd = out_rd;
            idle(3); #1;
            check(!out_valid && out_rd == hold_rd && !out_kerr, "R2",
                  $sformatf("idle v%0d rd%0d, expected v0 rd%0d", out_valid, out_rd, hold_rd));
        end

        // pseudo-random mixed stream
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[15:13] == 3'b000) send(kcode(int'(lfsr[7:0]) % 12), 1'b1, "R6");
            else                       send(lfsr[7:0], 1'b0, "R6");
        end
        idle(2);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule